// File: doc/BRIEF.md
# Tagged Branch Target Buffer Next-PC Predictor

This block chooses the next fetch address for an instruction fetch stage before the current instruction has been decoded. It keeps a direct-mapped table of control-transfer records. Each record holds a valid flag, the complete address of the branch or jump it describes, that instruction's last known target, and a 2-bit saturating direction counter. Every cycle the fetch address selects one record. If the record is valid, its stored address equals the fetch address in full, and its counter leans towards taken, the block offers the stored target. In every other case it offers the sequential address, fetch address plus 4.

Because the complete instruction address is compared, an ordinary instruction whose address lands on the same slot as a jump never causes a redirect. Later in the pipeline, a resolution port reports each finished instruction. The report gives the instruction's address, whether it is a control transfer, its actual direction and target, and the next address that was predicted for it at fetch. The block compares the prediction with the actual outcome. When they differ, it raises a kill with the correct restart address. It then trains, retargets or allocates the matching table record.

Top module: `btb_predictor`

## Requirements
- R1: A synchronous active-high reset clears every valid flag. Until a record is allocated afterwards, every lookup gives pred_taken = 0 and pred_next_pc = fetch_pc + 4.
- R2: The slot is selected by fetch_pc[IDX_W+1:2], with IDX_W = 7 (128 slots) by default. Allocating a different taken control instruction at the same slot replaces the earlier occupant, and the earlier occupant then falls through to its own address plus 4.
- R3: When the selected record is valid, its stored address equals fetch_pc, and counter bit 1 is set, pred_taken is 1 and pred_next_pc is the stored target. This happens in the same cycle as the lookup.
- R4: An instruction whose address maps to an occupied slot but differs from the stored address is not redirected. For example, address 1028 with a jump recorded at address 4 yields 1032.
- R5: The counter encodes 11 strongly taken, 10 weakly taken, 01 weakly not taken and 00 strongly not taken. It counts up on taken and down on not taken, and saturates at 11 and 00. Bit 1 is the prediction.
- R6: A resolved taken control instruction that misses in the table is written into its slot with valid = 1, its address, its target and counter 10. From the next cycle on, fetching that address predicts the target.
- R7: A resolved not-taken control instruction that misses in the table is not allocated.
- R8: A resolution with res_is_ctrl = 0 never changes the table, whatever res_taken and res_target carry. Its actual next address is res_pc + 4.
- R9: The actual next address is res_target for a taken control instruction and res_pc + 4 otherwise. When res_valid is 1 and res_pred_next differs from it, kill is 1 and redirect_pc equals it in the same cycle; a hitting record then gets both its counter trained and its target replaced by res_target. When they agree, kill is 0 and only the counter is trained.
- R10: A lookup and a table write to the same slot in the same cycle return the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_pc | input | PC_W | Address being fetched this cycle |
| pred_next_pc | output | PC_W | Predicted next fetch address |
| pred_taken | output | 1 | Lookup hit a record whose counter predicts taken |
| res_valid | input | 1 | A resolved instruction is reported this cycle |
| res_pc | input | PC_W | Address of the resolved instruction |
| res_is_ctrl | input | 1 | Resolved instruction is a branch or jump |
| res_taken | input | 1 | Actual direction of the resolved instruction |
| res_target | input | PC_W | Actual target of the resolved control instruction |
| res_pred_next | input | PC_W | Next address that was predicted for it at fetch |
| kill | output | 1 | Prediction was wrong; younger instructions must be discarded |
| redirect_pc | output | PC_W | Correct next address when kill is set |

## Verification
The lookup result and the kill/redirect pair are combinational, so they are due in the same cycle as the fetch address or resolution that causes them. Table changes caused by a resolution become visible one clock edge later. For that reason the bench drives each stimulus just after a rising edge and queues its expected values. A monitor pops and compares the queued values at the following falling edge. Effects of a write are queued only for the cycle after the resolution was presented. A lookup issued in the same cycle as the write is expected to show the old contents.

// File: rtl/btb_pkg.sv
package btb_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_STRONG_NT = 2'b00;
  localparam ctr_t CTR_WEAK_T    = 2'b10;
  localparam ctr_t CTR_STRONG_T  = 2'b11;

  // Saturating two-bit direction counter update.
  function automatic ctr_t ctr_train(input ctr_t c, input logic taken);
    ctr_t n;
    n = c;
    if (taken && (c != CTR_STRONG_T)) n = c + 2'b01;
    else if (!taken && (c != CTR_STRONG_NT)) n = c - 2'b01;
    return n;
  endfunction

  function automatic logic ctr_says_taken(input ctr_t c);
    return c[1];
  endfunction

endpackage

// File: rtl/btb_store.sv
module btb_store
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  // read port for fetch lookup
  input  logic [IDX_W-1:0] a_idx,
  output logic             a_vld,
  output logic [PC_W-1:0]  a_tag,
  output logic [PC_W-1:0]  a_tgt,
  output ctr_t             a_ctr,
  // read port for resolution
  input  logic [IDX_W-1:0] b_idx,
  output logic             b_vld,
  output logic [PC_W-1:0]  b_tag,
  output logic [PC_W-1:0]  b_tgt,
  output ctr_t             b_ctr,
  // write port
  input  logic             we,
  input  logic [IDX_W-1:0] w_idx,
  input  logic [PC_W-1:0]  w_tag,
  input  logic [PC_W-1:0]  w_tgt,
  input  ctr_t             w_ctr
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] vld_q;
  logic [PC_W-1:0]  tag_mem [DEPTH];
  logic [PC_W-1:0]  tgt_mem [DEPTH];
  ctr_t             ctr_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else if (we) vld_q[w_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (we) begin
      tag_mem[w_idx] <= w_tag;
      tgt_mem[w_idx] <= w_tgt;
      ctr_mem[w_idx] <= w_ctr;
    end
  end

  // Reads see pre-write contents: writes land only at the edge.
  assign a_vld = vld_q[a_idx];
  assign a_tag = tag_mem[a_idx];
  assign a_tgt = tgt_mem[a_idx];
  assign a_ctr = ctr_mem[a_idx];

  assign b_vld = vld_q[b_idx];
  assign b_tag = tag_mem[b_idx];
  assign b_tgt = tgt_mem[b_idx];
  assign b_ctr = ctr_mem[b_idx];

endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 7
) (
  input  logic [PC_W-1:0]  fetch_pc,
  output logic [IDX_W-1:0] idx,
  input  logic             e_vld,
  input  logic [PC_W-1:0]  e_tag,
  input  logic [PC_W-1:0]  e_tgt,
  input  ctr_t             e_ctr,
  output logic             hit,
  output logic             taken,
  output logic [PC_W-1:0]  next_pc
);
  assign idx     = fetch_pc[IDX_W+1:2];
  assign hit     = e_vld && (e_tag == fetch_pc);
  assign taken   = hit && ctr_says_taken(e_ctr);
  assign next_pc = taken ? e_tgt : fetch_pc + PC_W'(4);
endmodule

// File: rtl/btb_train.sv
module btb_train
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 7
) (
  input  logic             res_valid,
  input  logic [PC_W-1:0]  res_pc,
  input  logic             res_is_ctrl,
  input  logic             res_taken,
  input  logic [PC_W-1:0]  res_target,
  input  logic [PC_W-1:0]  res_pred_next,
  output logic [IDX_W-1:0] idx,
  input  logic             e_vld,
  input  logic [PC_W-1:0]  e_tag,
  input  logic [PC_W-1:0]  e_tgt,
  input  ctr_t             e_ctr,
  output logic             hit,
  output logic             mispred,
  output logic [PC_W-1:0]  actual_next,
  output logic             we,
  output logic [PC_W-1:0]  w_tag,
  output logic [PC_W-1:0]  w_tgt,
  output ctr_t             w_ctr
);
  logic ctrl_taken;

  assign idx         = res_pc[IDX_W+1:2];
  assign ctrl_taken  = res_is_ctrl && res_taken;
  assign actual_next = ctrl_taken ? res_target : res_pc + PC_W'(4);
  assign mispred     = res_valid && (res_pred_next != actual_next);
  assign hit         = e_vld && (e_tag == res_pc);

  // Only control transfers write; a miss is allocated only when taken.
  assign we    = res_valid && res_is_ctrl && (hit || res_taken);
  assign w_tag = res_pc;

  always_comb begin
    if (hit) begin
      w_ctr = ctr_train(e_ctr, res_taken);
      w_tgt = mispred ? res_target : e_tgt;
    end else begin
      w_ctr = CTR_WEAK_T;
      w_tgt = res_target;
    end
  end
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] fetch_pc,
  output logic [PC_W-1:0] pred_next_pc,
  output logic            pred_taken,
  input  logic            res_valid,
  input  logic [PC_W-1:0] res_pc,
  input  logic            res_is_ctrl,
  input  logic            res_taken,
  input  logic [PC_W-1:0] res_target,
  input  logic [PC_W-1:0] res_pred_next,
  output logic            kill,
  output logic [PC_W-1:0] redirect_pc
);
  // named internal events
  logic [IDX_W-1:0] f_idx, r_idx;
  logic             f_vld, r_vld, f_hit, res_hit, wr_en;
  logic [PC_W-1:0]  f_tag, f_tgt, r_tag, r_tgt, w_tag, w_tgt;
  ctr_t             f_ctr, r_ctr, w_ctr;

  btb_store #(.PC_W(PC_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst),
    .a_idx(f_idx), .a_vld(f_vld), .a_tag(f_tag), .a_tgt(f_tgt), .a_ctr(f_ctr),
    .b_idx(r_idx), .b_vld(r_vld), .b_tag(r_tag), .b_tgt(r_tgt), .b_ctr(r_ctr),
    .we(wr_en), .w_idx(r_idx), .w_tag(w_tag), .w_tgt(w_tgt), .w_ctr(w_ctr)
  );

  btb_lookup #(.PC_W(PC_W), .IDX_W(IDX_W)) u_lookup (
    .fetch_pc(fetch_pc), .idx(f_idx),
    .e_vld(f_vld), .e_tag(f_tag), .e_tgt(f_tgt), .e_ctr(f_ctr),
    .hit(f_hit), .taken(pred_taken), .next_pc(pred_next_pc)
  );

  btb_train #(.PC_W(PC_W), .IDX_W(IDX_W)) u_train (
    .res_valid(res_valid), .res_pc(res_pc), .res_is_ctrl(res_is_ctrl),
    .res_taken(res_taken), .res_target(res_target), .res_pred_next(res_pred_next),
    .idx(r_idx), .e_vld(r_vld), .e_tag(r_tag), .e_tgt(r_tgt), .e_ctr(r_ctr),
    .hit(res_hit), .mispred(kill), .actual_next(redirect_pc),
    .we(wr_en), .w_tag(w_tag), .w_tgt(w_tgt), .w_ctr(w_ctr)
  );

  logic unused_f_hit;
  assign unused_f_hit = f_hit;
endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] fetch_pc,
  input logic [PC_W-1:0] pred_next_pc,
  input logic            pred_taken,
  input logic            res_valid,
  input logic [PC_W-1:0] res_pc,
  input logic            res_is_ctrl,
  input logic            res_taken,
  input logic [PC_W-1:0] res_target,
  input logic            kill,
  input logic            res_hit,
  input logic            wr_en
);
  // R1: first cycle after reset nothing is predicted taken
  p_clear_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !pred_taken);

  // R8: writes come only from resolved control transfers
  p_write_only_ctrl_r8: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (res_valid && res_is_ctrl));

  // R8: a non-control resolution leaves the prediction for a held fetch PC unchanged
  p_nonctrl_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(res_valid && !res_is_ctrl) && $stable(fetch_pc))
      |-> $stable(pred_next_pc));

  // R6: a taken miss is predicted taken to its target on the next cycle
  p_alloc_taken_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(res_valid && res_is_ctrl && res_taken && !res_hit)
      && fetch_pc == $past(res_pc))
      |-> (pred_taken && pred_next_pc == $past(res_target)));

  // R7: a not-taken miss is not allocated
  p_no_alloc_nt_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(res_valid && res_is_ctrl && !res_taken && !res_hit)
      && fetch_pc == $past(res_pc))
      |-> !pred_taken);

  // R9: kill only accompanies a reported resolution
  p_kill_needs_res_r9: assert property (@(posedge clk) disable iff (rst)
    kill |-> res_valid);
endmodule

bind btb_predictor btb_predictor_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .pred_next_pc(pred_next_pc),
  .pred_taken(pred_taken), .res_valid(res_valid), .res_pc(res_pc),
  .res_is_ctrl(res_is_ctrl), .res_taken(res_taken), .res_target(res_target),
  .kill(kill), .res_hit(res_hit), .wr_en(wr_en)
);

// File: tb/tb_btb_predictor.sv
module tb_btb_predictor;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [PC_W-1:0] fetch_pc = '0;
  logic [PC_W-1:0] pred_next_pc;
  logic            pred_taken;
  logic            res_valid = 1'b0;
  logic [PC_W-1:0] res_pc = '0;
  logic            res_is_ctrl = 1'b0;
  logic            res_taken = 1'b0;
  logic [PC_W-1:0] res_target = '0;
  logic [PC_W-1:0] res_pred_next = '0;
  logic            kill;
  logic [PC_W-1:0] redirect_pc;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    int          sel;   // 0 next pc, 1 taken, 2 kill, 3 redirect
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  btb_predictor dut (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .pred_next_pc(pred_next_pc),
    .pred_taken(pred_taken), .res_valid(res_valid), .res_pc(res_pc),
    .res_is_ctrl(res_is_ctrl), .res_taken(res_taken), .res_target(res_target),
    .res_pred_next(res_pred_next), .kill(kill), .redirect_pc(redirect_pc)
  );

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic push_exp(input int sel, input logic [31:0] e, input string req);
    item_t it;
    it.sel = sel; it.exp = e; it.req = req;
    sb.push_back(it);
  endtask

  task automatic resolve(input logic [31:0] pc, input logic ctrl, input logic tk,
                         input logic [31:0] tgt, input logic [31:0] pn);
    res_valid = 1'b1; res_pc = pc; res_is_ctrl = ctrl;
    res_taken = tk; res_target = tgt; res_pred_next = pn;
  endtask

  task automatic idle();
    res_valid = 1'b0;
  endtask

  // monitor: compare queued expectations at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        case (it.sel)
          0: act = pred_next_pc;
          1: act = {31'd0, pred_taken};
          2: act = {31'd0, kill};
          default: act = redirect_pc;
        endcase
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst = 1'b0;
    // R1: empty table after reset
    fetch_pc = 32'h40; push_exp(0, 32'h44, "R1"); push_exp(1, 0, "R1");
    cyc();
    // jump at 4 -> 0x200 allocated; same-cycle lookup sees old contents (R10)
    fetch_pc = 32'h4; resolve(32'h4, 1, 1, 32'h200, 32'h8);
    push_exp(0, 32'h8, "R10"); push_exp(2, 1, "R9"); push_exp(3, 32'h200, "R9");
    cyc(); idle();
    push_exp(0, 32'h200, "R6"); push_exp(1, 1, "R3");
    cyc();
    // R4: aliasing address 1028 falls through
    fetch_pc = 32'd1028; push_exp(0, 32'd1032, "R4"); push_exp(1, 0, "R4");
    cyc();
    // not-taken mispredict: counter 10 -> 01
    fetch_pc = 32'h4; resolve(32'h4, 1, 0, 32'h200, 32'h200);
    push_exp(2, 1, "R9"); push_exp(3, 32'h8, "R9");
    cyc(); idle();
    push_exp(0, 32'h8, "R5"); push_exp(1, 0, "R5");
    cyc();
    // taken with new target: counter 01 -> 10, target replaced
    resolve(32'h4, 1, 1, 32'h300, 32'h8);
    push_exp(2, 1, "R9"); push_exp(3, 32'h300, "R9");
    cyc(); idle();
    push_exp(0, 32'h300, "R9");
    cyc();
    // correct predictions: 10 -> 11 -> 11 (saturate)
    resolve(32'h4, 1, 1, 32'h300, 32'h300); push_exp(2, 0, "R9");
    cyc();
    resolve(32'h4, 1, 1, 32'h300, 32'h300); push_exp(2, 0, "R5");
    cyc();
    // one not-taken: 11 -> 10, still taken
    resolve(32'h4, 1, 0, 32'h300, 32'h300);
    push_exp(2, 1, "R9"); push_exp(3, 32'h8, "R9");
    cyc(); idle();
    push_exp(0, 32'h300, "R5"); push_exp(1, 1, "R5");
    cyc();
    // R8: non-control resolution with stray taken/target
    resolve(32'd1028, 0, 1, 32'h999, 32'd1032); push_exp(2, 0, "R8");
    cyc(); idle();
    push_exp(0, 32'h300, "R8");
    cyc();
    fetch_pc = 32'd1028; push_exp(0, 32'd1032, "R8");
    cyc();
    // R7: not-taken miss not allocated
    resolve(32'h10, 1, 0, 32'h500, 32'h14); push_exp(2, 0, "R7");
    cyc(); idle();
    fetch_pc = 32'h10; push_exp(0, 32'h14, "R7"); push_exp(1, 0, "R7");
    cyc();
    // R2: 516 shares slot 1 with 4 and replaces it
    resolve(32'd516, 1, 1, 32'h700, 32'd520);
    push_exp(2, 1, "R9"); push_exp(3, 32'h700, "R9");
    cyc(); idle();
    fetch_pc = 32'd516; push_exp(0, 32'h700, "R2");
    cyc();
    fetch_pc = 32'h4; push_exp(0, 32'h8, "R2"); push_exp(1, 0, "R2");
    cyc();
    // R1: reset again clears the table
    rst = 1'b1;
    cyc(); cyc();
    rst = 1'b0;
    fetch_pc = 32'd516; push_exp(0, 32'd520, "R1"); push_exp(1, 0, "R1");
    cyc();
    @(negedge clk);
    #1;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule